// File: doc/BRIEF.md
# Regulator Operating Mode Controller

This block decides, once per clock, in which mode a charge-pump-fed linear regulator runs: switched off, plain linear pass, step-down pumping or step-up pumping. It receives seven single-bit comparator results from the analog side. These cover input supply health, the enable level, two input-voltage levels, two pump-output levels and a light/heavy load indication. It produces a one-hot mode word plus two strobes: one that runs the pump switches and one that enables the linear regulator.

Every comparator bit first crosses into the clock domain through its own synchroniser chain. A single state register then applies the transition rules. One memory bit records that the input has been seen above the step-up release level, and step-up entry depends on it. The analog thresholds, their hysteresis, the switch drivers and the regulation loop all belong to neighbouring blocks.

Top module: `regmode_ctrl`

## Requirements
- R1: A low `rst_n` sampled on a rising clock edge forces the mode to off (`mode_o` = 4'b0001), drives both strobes low and clears every synchroniser stage.
- R2: `mode_o` is one-hot with bit 0 = off, bit 1 = linear, bit 2 = step-down, bit 3 = step-up; `pump_run_o` is high exactly in step-down and step-up; `reg_en_o` is high in every mode except off.
- R3: A comparator change that is stable before a rising edge acts on the mode at the (SYNC_STAGES+1)-th rising edge, counting that edge as the first; after SYNC_STAGES edges the old mode is still shown.
- R4: The mode is off, or becomes off from any other mode, whenever `supply_ok_i` or `enable_ok_i` is low.
- R5: Leaving off always goes to linear mode.
- R6: From linear, `vin_above_dn_i` high with `load_heavy_i` high moves to step-down.
- R7: Step-down returns to linear when `vin_above_dn_i` is low and `vcp_below_dn_i` is high; either condition alone keeps step-down while the load stays heavy.
- R8: Step-down returns to linear when `load_heavy_i` goes low.
- R9: From linear, `vcp_below_up_i` high with `vin_above_up_i` low moves to step-up, provided the input-seen-high memory is set; that memory is set in any cycle where the synchronised `vin_above_up_i` is high.
- R10: Without that memory the step-up condition leaves linear mode unchanged; the memory is cleared in the cycle the mode enters off.
- R11: Step-up returns to linear when `vin_above_up_i` goes high.
- R12: When the step-down and step-up entry conditions hold together in linear mode, step-down wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| supply_ok_i | input | 1 | Input is above the undervoltage-lockout level |
| enable_ok_i | input | 1 | Enable is above its threshold |
| vin_above_dn_i | input | 1 | Input is above the step-down entry level |
| vcp_below_dn_i | input | 1 | Pump output is below the step-down exit level |
| vin_above_up_i | input | 1 | Input is above the step-up release level |
| vcp_below_up_i | input | 1 | Pump output is below the step-up entry level |
| load_heavy_i | input | 1 | Load current is above the pump-activity threshold |
| mode_o | output | 4 | One-hot mode: bit0 off, bit1 linear, bit2 step-down, bit3 step-up |
| pump_run_o | output | 1 | Pump switching active |
| reg_en_o | output | 1 | Linear regulator enabled |

## Verification
The assertions assume that each comparator bit is a level, held long enough to pass the synchroniser chain. They do not expect the mode to follow glitches narrower than a clock. The step-up and step-down rules are checked against the synchronised flags, not the raw pins. This makes the properties independent of when the analog side toggles. The stimulus changes the flags only on the falling edge and holds each pattern for SYNC_STAGES+1 rising edges before the next one, so every pattern reaches the state register intact.

// File: rtl/regmode_pkg.sv
package regmode_pkg;

   typedef enum logic [3:0] {
      MODE_OFF  = 4'b0001,
      MODE_LIN  = 4'b0010,
      MODE_DOWN = 4'b0100,
      MODE_UP   = 4'b1000
   } mode_e;

   // comparator bundle, bit 0 is supply_ok
   typedef struct packed {
      logic load_heavy;
      logic vcp_below_up;
      logic vin_above_up;
      logic vcp_below_dn;
      logic vin_above_dn;
      logic enable_ok;
      logic supply_ok;
   } cmp_flags_t;

   localparam int CMP_W = $bits(cmp_flags_t);

endpackage

// File: rtl/regmode_sync.sv
module regmode_sync #(
   parameter int WIDTH  = 7,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("regmode_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("regmode_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/regmode_hist.sv
module regmode_hist (
   input  logic clk,
   input  logic rst_n,
   input  logic seen_high_i,
   input  logic clear_i,
   output logic hist_o
);

   logic hist_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          hist_q <= 1'b0;
      else if (clear_i)    hist_q <= 1'b0;
      else if (seen_high_i) hist_q <= 1'b1;
   end

   assign hist_o = hist_q;

endmodule

// File: rtl/regmode_fsm.sv
module regmode_fsm
   import regmode_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  cmp_flags_t flags_i,
   input  logic       hist_i,
   output mode_e      mode_o,
   output logic       enter_off_o
);

   mode_e state_q, state_d;
   logic  power_ok, dn_enter, dn_leave, up_enter, up_leave;

   always_comb begin
      power_ok = flags_i.supply_ok & flags_i.enable_ok;
      dn_enter = flags_i.vin_above_dn & flags_i.load_heavy;
      dn_leave = (~flags_i.vin_above_dn & flags_i.vcp_below_dn) | ~flags_i.load_heavy;
      up_enter = flags_i.vcp_below_up & ~flags_i.vin_above_up & hist_i;
      up_leave = flags_i.vin_above_up;
   end

   always_comb begin
      state_d = state_q;
      if (!power_ok) begin
         state_d = MODE_OFF;
      end else begin
         unique case (state_q)
            MODE_OFF:  state_d = MODE_LIN;
            MODE_LIN: begin
               if (dn_enter)      state_d = MODE_DOWN;
               else if (up_enter) state_d = MODE_UP;
            end
            MODE_DOWN: if (dn_leave) state_d = MODE_LIN;
            MODE_UP:   if (up_leave) state_d = MODE_LIN;
            default:   state_d = MODE_OFF;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= MODE_OFF;
      else        state_q <= state_d;
   end

   assign mode_o      = state_q;
   assign enter_off_o = (state_d == MODE_OFF) && (state_q != MODE_OFF);

   // R4: power loss forces off on the next edge
   a_r4_off_on_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
      !(flags_i.supply_ok && flags_i.enable_ok) |=> (state_q == MODE_OFF));

   // R5: off only ever exits to linear
   a_r5_off_exits_to_lin: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MODE_OFF) |=> (state_q == MODE_OFF || state_q == MODE_LIN));

   // R6 and R12: step-down entry taken, even if step-up also qualifies
   a_r6_dn_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MODE_LIN && flags_i.supply_ok && flags_i.enable_ok &&
       flags_i.vin_above_dn && flags_i.load_heavy) |=> (state_q == MODE_DOWN));

   // R10: no step-up without the memory bit
   a_r10_no_up_without_hist: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MODE_LIN && !hist_i) |=> (state_q != MODE_UP));

   // R11: step-up released when input climbs
   a_r11_up_release: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == MODE_UP && flags_i.supply_ok && flags_i.enable_ok &&
       flags_i.vin_above_up) |=> (state_q == MODE_LIN));

endmodule

// File: rtl/regmode_ctrl.sv
module regmode_ctrl
   import regmode_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       supply_ok_i,
   input  logic       enable_ok_i,
   input  logic       vin_above_dn_i,
   input  logic       vcp_below_dn_i,
   input  logic       vin_above_up_i,
   input  logic       vcp_below_up_i,
   input  logic       load_heavy_i,
   output logic [3:0] mode_o,
   output logic       pump_run_o,
   output logic       reg_en_o
);

   cmp_flags_t raw_flags, sync_flags;
   logic       hist, enter_off;
   mode_e      mode;

   always_comb begin
      raw_flags.supply_ok    = supply_ok_i;
      raw_flags.enable_ok    = enable_ok_i;
      raw_flags.vin_above_dn = vin_above_dn_i;
      raw_flags.vcp_below_dn = vcp_below_dn_i;
      raw_flags.vin_above_up = vin_above_up_i;
      raw_flags.vcp_below_up = vcp_below_up_i;
      raw_flags.load_heavy   = load_heavy_i;
   end

   regmode_sync #(.WIDTH(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (raw_flags),
      .sync_o  (sync_flags)
   );

   regmode_hist u_hist (
      .clk         (clk),
      .rst_n       (rst_n),
      .seen_high_i (sync_flags.vin_above_up),
      .clear_i     (enter_off),
      .hist_o      (hist)
   );

   regmode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .flags_i     (sync_flags),
      .hist_i      (hist),
      .mode_o      (mode),
      .enter_off_o (enter_off)
   );

   assign mode_o     = mode;
   assign pump_run_o = (mode == MODE_DOWN) || (mode == MODE_UP);
   assign reg_en_o   = (mode != MODE_OFF);

   // R2: mode word stays one-hot
   a_r2_mode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mode_o) == 1);

   // R2: pump never runs while the regulator is disabled
   a_r2_pump_needs_reg: assert property (@(posedge clk) disable iff (!rst_n)
      pump_run_o |-> reg_en_o);

endmodule

// File: tb/regmode_ctrl_tb.sv
module regmode_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;

   // stimulus vector: bit6 supply, bit5 enable, bit4 vin>dn, bit3 vcp<dn,
   // bit2 vin>up, bit1 vcp<up, bit0 load heavy
   localparam logic [6:0] F_SUP  = 7'b1000000;
   localparam logic [6:0] F_EN   = 7'b0100000;
   localparam logic [6:0] F_VDN  = 7'b0010000;
   localparam logic [6:0] F_CDN  = 7'b0001000;
   localparam logic [6:0] F_VUP  = 7'b0000100;
   localparam logic [6:0] F_CUP  = 7'b0000010;
   localparam logic [6:0] F_LOAD = 7'b0000001;
   localparam logic [6:0] F_ON   = F_SUP | F_EN;

   localparam logic [3:0] M_OFF  = 4'b0001;
   localparam logic [3:0] M_LIN  = 4'b0010;
   localparam logic [3:0] M_DOWN = 4'b0100;
   localparam logic [3:0] M_UP   = 4'b1000;

   typedef struct {
      logic [3:0] mode;
      string      tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [6:0] flags = '0;
   logic [3:0] mode_o;
   logic pump_run_o, reg_en_o;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fail = 0;
   logic [3:0] cur_mode = M_OFF;
   bit   done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   regmode_ctrl #(.SYNC_STAGES(SYNC)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .supply_ok_i    (flags[6]),
      .enable_ok_i    (flags[5]),
      .vin_above_dn_i (flags[4]),
      .vcp_below_dn_i (flags[3]),
      .vin_above_up_i (flags[2]),
      .vcp_below_up_i (flags[1]),
      .load_heavy_i   (flags[0]),
      .mode_o         (mode_o),
      .pump_run_o     (pump_run_o),
      .reg_en_o       (reg_en_o)
   );

   // monitor: pops expectations and compares against the ports
   initial begin
      forever begin
         exp_t e;
         logic exp_pump, exp_reg;
         wait (exp_q.size() != 0);
         e = exp_q.pop_front();
         exp_pump = e.mode[2] | e.mode[3];
         exp_reg  = ~e.mode[0];
         n_checks++;
         if (mode_o !== e.mode || pump_run_o !== exp_pump || reg_en_o !== exp_reg) begin
            n_fail++;
            $display("FAIL %s: mode=%b pump=%b reg=%b expected mode=%b pump=%b reg=%b",
                     e.tag, mode_o, pump_run_o, reg_en_o, e.mode, exp_pump, exp_reg);
         end
      end
   end

   task automatic push(input logic [3:0] m, input string tag);
      exp_t e;
      e.mode = m;
      e.tag  = tag;
      exp_q.push_back(e);
      #1;
   endtask

   // called at a falling edge; drives, checks old mode just before the
   // update edge (R3), then the new mode after it
   task automatic step(input logic [6:0] f, input logic [3:0] new_mode, input string tag);
      flags = f;
      repeat (SYNC) @(posedge clk);
      @(negedge clk);
      push(cur_mode, "R3 latency hold");
      @(posedge clk);
      @(negedge clk);
      push(new_mode, tag);
      cur_mode = new_mode;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      push(M_OFF, "R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);

      step(F_SUP, M_OFF, "R4 enable low keeps off");
      step(F_ON, M_LIN, "R5 off exits to linear / R2 strobes");
      step(F_ON | F_VDN | F_LOAD, M_DOWN, "R6 linear to step-down");
      step(F_ON | F_LOAD, M_DOWN, "R7 input low alone keeps step-down");
      step(F_ON | F_VDN | F_CDN | F_LOAD, M_DOWN, "R7 pump low alone keeps step-down");
      step(F_ON | F_CDN | F_LOAD, M_LIN, "R7 joint voltage exit");
      step(F_ON | F_VDN | F_LOAD, M_DOWN, "R6 re-enter step-down");
      step(F_ON | F_VDN, M_LIN, "R8 light load exit");
      step(F_ON | F_CUP, M_LIN, "R10 no step-up without memory");
      step(F_ON | F_VUP, M_LIN, "R9 memory set, still linear");
      step(F_ON | F_CUP, M_UP, "R9 step-up entry");
      step(F_ON | F_CUP | F_VUP, M_LIN, "R11 step-up release");
      step(F_ON | F_CUP | F_VDN | F_LOAD, M_DOWN, "R12 step-down priority");
      step(F_SUP | F_CUP, M_OFF, "R4 enable loss from step-down");
      step(F_ON | F_CUP, M_LIN, "R10 memory cleared by off");
      step(F_ON | F_VUP, M_LIN, "R9 memory set again");
      step(F_ON | F_CUP, M_UP, "R9 step-up entry again");
      step(F_EN | F_CUP, M_OFF, "R4 supply loss from step-up");
      step(F_ON, M_LIN, "R5 restart");

      // R1: reset in the middle of operation
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      push(M_OFF, "R1 reset mid-run");
      cur_mode = M_OFF;
      rst_n = 1'b1;
      step(F_ON, M_LIN, "R1 synchroniser restart to linear");

      repeat (2) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

endmodule